// File: doc/BRIEF.md
# Dual-Line Ring and Hook Supervision Controller

This block is the host-side sequencer for a two-port subscriber line interface. It drives the interface's three mode bits and two port-select bits, and it reads back three active-low detector outputs: one shared supervision detector and one detector per port. While nothing is happening, it keeps both ports in high-impedance feed so that either telephone can be seen going off-hook. When a telephone goes off-hook, it moves the interface to active feed with only that port connected.

On a ring request it produces the ring waveform itself. It holds the ring mode code and inverts the polarity bit every half ring period. Ringing runs as a fixed cadence of bursts and pauses. A low supervision detector during a burst is a ring trip: the controller freezes the polarity bit, then connects the answering port in active feed. When both ports were rung together, the controller isolates one port at a time to find which one answered. A call ends only when the off-hook indication has been gone for a programmable persistence time.

All timing values are clock-count parameters: the ring half-period, the burst length, the pause length, the number of bursts, the probe settle time and the on-hook persistence. The three detector inputs are asynchronous and are synchronised inside the block.

Top module: `ring_sup_ctrl`

## Requirements
- R1: After reset and whenever idle, the outputs are D0=0, D1=0, D2=0, P1=1, P2=1. This is high-impedance feed with both ports monitored.
- R2: In idle, a low port-1 detector (det1N) selects active feed for port 1: D0=0, D1=1, D2=0, P1=1, P2=0. A low port-2 detector (det2N) selects the same mode with P1=0, P2=1. When both detectors are low, port 1 wins.
- R3: A ring request accepted in idle starts a burst. During the burst D0=1 and D1=0, and P1/P2 equal ringLines bit 0/bit 1 (bit 0 is port 1, bit 1 is port 2). D2 starts at 0 and inverts every HALF_CYC clock cycles.
- R4: A burst lasts BURST_CYC cycles. A pause follows for PAUSE_CYC cycles, with the idle outputs of R1. After MAX_BURSTS bursts with no answer, the controller returns to idle.
- R5: A low detN during a burst is a ring trip. D2 is held for one cycle, then the single rung port is placed in active feed (R2 encoding).
- R6: After a trip with both ports rung, the controller holds active mode with P1=0, P2=1 for PROBE_CYC cycles. If detN is then low, port 2 is connected. Otherwise it holds P1=1, P2=0 for PROBE_CYC cycles. If detN is then low, port 1 is connected. Otherwise the controller returns to idle.
- R7: A low det1N or det2N during a pause ends ringing and connects that port in active feed. Port 1 has priority.
- R8: In active feed, the controller returns to idle only after the synchronised detN has been high for ONHOOK_CYC consecutive cycles. A shorter high interval is ignored.
- R9: Each detector input passes two synchronising flip-flops. A detector change made between clock edges reaches the outputs after the third rising edge, and not before.
- R10: A ring request is accepted only in idle and only with a non-zero ringLines. Otherwise it has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ringReq | input | 1 | One-cycle ring request strobe |
| ringLines | input | 2 | Ports to ring: bit 0 port 1, bit 1 port 2 |
| detN | input | 1 | Supervision detector, active low (off-hook or ring trip) |
| det1N | input | 1 | Port-1 detector in high-impedance feed, active low |
| det2N | input | 1 | Port-2 detector in high-impedance feed, active low |
| lineD0 | output | 1 | Mode bit 0 |
| lineD1 | output | 1 | Mode bit 1 |
| lineD2 | output | 1 | Mode bit 2, polarity / ring toggle |
| selP1 | output | 1 | Port-1 select |
| selP2 | output | 1 | Port-2 select |

## Verification
The assertions assume that the detector inputs respond to the pins the block drives, the way the line interface would. In particular, detN only falls during ringing when a selected port is off-hook, and a probe sees the port it left connected. The bench builds this from a small line model: two hook flags, gated by the select and mode outputs, drive all three detectors. The stimulus therefore never presents a detector value that the driven mode could not produce. Ring requests are single-cycle strobes applied at falling edges, and hook changes are also made at falling edges.

// File: rtl/ring_sup_pkg.sv
package ring_sup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_BURST  = 3'd2,
    ST_PAUSE  = 3'd3,
    ST_TRIP   = 3'd4,
    ST_PROBE1 = 3'd5,
    ST_PROBE2 = 3'd6
  } supState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;
    logic polClr;
    logic ringRun;
    logic onArm;
    logic burstInc;
    logic burstClr;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic detN;
    logic det1N;
    logic det2N;
    logic pol;
    logic burstEnd;
    logic pauseEnd;
    logic probeEnd;
    logic onhookEnd;
    logic lastBurst;
  } dpFlags_t;

  typedef struct packed {
    logic d0;
    logic d1;
    logic d2;
    logic p1;
    logic p2;
  } linePins_t;

endpackage

// File: rtl/ring_sup_dp.sv
module ring_sup_dp
  import ring_sup_pkg::*;
#(
  parameter int HALF_CYC   = 8,
  parameter int BURST_CYC  = 64,
  parameter int PAUSE_CYC  = 48,
  parameter int PROBE_CYC  = 6,
  parameter int ONHOOK_CYC = 20,
  parameter int MAX_BURSTS = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic [2:0] detRaw,
  input  dpCmd_t   cmd,
  output dpFlags_t flags
);

  localparam int PH_A   = (BURST_CYC > PAUSE_CYC) ? BURST_CYC : PAUSE_CYC;
  localparam int PH_MAX = (PH_A > PROBE_CYC) ? PH_A : PROBE_CYC;
  localparam int PW     = $clog2(PH_MAX + 1);
  localparam int HW     = $clog2(HALF_CYC + 1);
  localparam int OW     = $clog2(ONHOOK_CYC + 1);
  localparam int BW     = $clog2(MAX_BURSTS + 1);

  logic [2:0]    detSync;
  logic [PW-1:0] phaseCnt;
  logic [HW-1:0] halfCnt;
  logic          pol;
  logic [OW-1:0] onCnt;
  logic [BW-1:0] burstCnt;

  // two-stage synchronisers, idle value is high (inactive)
  for (genvar i = 0; i < 3; i++) begin : g_sync
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= 2'b11;
      else       stg <= {stg[0], detRaw[i]};
    end
    assign detSync[i] = stg[1];
  end

  // phase timer shared by burst, pause and probe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             phaseCnt <= '0;
    else if (cmd.phaseClr)                 phaseCnt <= '0;
    else if (phaseCnt != PW'(PH_MAX - 1))  phaseCnt <= phaseCnt + PW'(1);
  end

  // ring polarity generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      pol     <= 1'b0;
    end else if (cmd.polClr) begin
      halfCnt <= '0;
      pol     <= 1'b0;
    end else if (cmd.ringRun) begin
      if (halfCnt == HW'(HALF_CYC - 1)) begin
        halfCnt <= '0;
        pol     <= ~pol;
      end else begin
        halfCnt <= halfCnt + HW'(1);
      end
    end
  end

  // on-hook persistence counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                onCnt <= '0;
    else if (!cmd.onArm || !detSync[0])       onCnt <= '0;
    else if (onCnt != OW'(ONHOOK_CYC - 1))    onCnt <= onCnt + OW'(1);
  end

  // burst counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             burstCnt <= '0;
    else if (cmd.burstClr) burstCnt <= '0;
    else if (cmd.burstInc) burstCnt <= burstCnt + BW'(1);
  end

  always_comb begin
    flags.detN      = detSync[0];
    flags.det1N     = detSync[1];
    flags.det2N     = detSync[2];
    flags.pol       = pol;
    flags.burstEnd  = (phaseCnt == PW'(BURST_CYC - 1));
    flags.pauseEnd  = (phaseCnt == PW'(PAUSE_CYC - 1));
    flags.probeEnd  = (phaseCnt == PW'(PROBE_CYC - 1));
    flags.onhookEnd = detSync[0] && (onCnt == OW'(ONHOOK_CYC - 1));
    flags.lastBurst = (burstCnt == BW'(MAX_BURSTS));
  end

  // R3: polarity only moves while ringing runs or is cleared
  a_r3_pol_hold : assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.ringRun && !cmd.polClr) |=> $stable(pol));

endmodule

// File: rtl/ring_sup_fsm.sv
module ring_sup_fsm
  import ring_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ringReq,
  input  logic [1:0] ringLines,
  input  dpFlags_t   flags,
  output dpCmd_t     cmd,
  output linePins_t  pins
);

  supState_t state, stateNext;
  logic [1:0] lineSel, lineNext;   // bit0 port 1, bit1 port 2
  logic [1:0] ringReg, ringNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lineSel <= 2'b01;
      ringReg <= 2'b00;
    end else begin
      state   <= stateNext;
      lineSel <= lineNext;
      ringReg <= ringNext;
    end
  end

  always_comb begin
    stateNext = state;
    lineNext  = lineSel;
    ringNext  = ringReg;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        cmd.polClr   = 1'b1;
        cmd.burstClr = 1'b1;
        if (!flags.det1N) begin
          stateNext = ST_ACTIVE;
          lineNext  = 2'b01;
        end else if (!flags.det2N) begin
          stateNext = ST_ACTIVE;
          lineNext  = 2'b10;
        end else if (ringReq && (ringLines != 2'b00)) begin
          stateNext = ST_BURST;
          ringNext  = ringLines;
        end
      end
      ST_ACTIVE: begin
        cmd.polClr = 1'b1;
        cmd.onArm  = 1'b1;
        if (flags.onhookEnd) stateNext = ST_IDLE;
      end
      ST_BURST: begin
        cmd.ringRun = 1'b1;
        if (!flags.detN) begin
          stateNext = ST_TRIP;
        end else if (flags.burstEnd) begin
          stateNext    = ST_PAUSE;
          cmd.burstInc = 1'b1;
        end
      end
      ST_TRIP: begin
        if (ringReg == 2'b11) begin
          stateNext = ST_PROBE1;
        end else begin
          stateNext = ST_ACTIVE;
          lineNext  = ringReg;
        end
      end
      ST_PAUSE: begin
        cmd.polClr = 1'b1;
        if (!flags.det1N) begin
          stateNext = ST_ACTIVE;
          lineNext  = 2'b01;
        end else if (!flags.det2N) begin
          stateNext = ST_ACTIVE;
          lineNext  = 2'b10;
        end else if (flags.pauseEnd) begin
          stateNext = flags.lastBurst ? ST_IDLE : ST_BURST;
        end
      end
      ST_PROBE1: begin
        cmd.polClr = 1'b1;
        if (flags.probeEnd) begin
          if (!flags.detN) begin
            stateNext = ST_ACTIVE;
            lineNext  = 2'b10;
          end else begin
            stateNext = ST_PROBE2;
          end
        end
      end
      ST_PROBE2: begin
        cmd.polClr = 1'b1;
        if (flags.probeEnd) begin
          if (!flags.detN) begin
            stateNext = ST_ACTIVE;
            lineNext  = 2'b01;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    cmd.phaseClr = (stateNext != state) || (state == ST_IDLE) || (state == ST_ACTIVE);
  end

  always_comb begin
    pins = '{d0: 1'b0, d1: 1'b0, d2: 1'b0, p1: 1'b1, p2: 1'b1};
    unique case (state)
      ST_ACTIVE: pins = '{d0: 1'b0, d1: 1'b1, d2: 1'b0, p1: lineSel[0], p2: lineSel[1]};
      ST_BURST,
      ST_TRIP:   pins = '{d0: 1'b1, d1: 1'b0, d2: flags.pol, p1: ringReg[0], p2: ringReg[1]};
      ST_PROBE1: pins = '{d0: 1'b0, d1: 1'b1, d2: 1'b0, p1: 1'b0, p2: 1'b1};
      ST_PROBE2: pins = '{d0: 1'b0, d1: 1'b1, d2: 1'b0, p1: 1'b1, p2: 1'b0};
      default:   ;
    endcase
  end

  // R2: active feed always connects exactly one port
  a_r2_one_line : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> ($countones(lineSel) == 1));

  // R5: polarity frozen across the trip cycle
  a_r5_trip_freeze : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRIP) |=> (flags.pol == $past(flags.pol)));

  // R6: second probe only follows the first
  a_r6_probe_order : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROBE2) |-> ($past(state) == ST_PROBE1 || $past(state) == ST_PROBE2));

  // R8: leaving active needs the supervision detector high
  a_r8_onhook_exit : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_ACTIVE) |-> $past(flags.detN));

  // R10: a burst is entered only from idle or a pause
  a_r10_ring_entry : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BURST && $past(state) != ST_BURST) |->
      ($past(state) == ST_IDLE || $past(state) == ST_PAUSE));

endmodule

// File: rtl/ring_sup_ctrl.sv
module ring_sup_ctrl
  import ring_sup_pkg::*;
#(
  parameter int HALF_CYC   = 8,
  parameter int BURST_CYC  = 64,
  parameter int PAUSE_CYC  = 48,
  parameter int PROBE_CYC  = 6,
  parameter int ONHOOK_CYC = 20,
  parameter int MAX_BURSTS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ringReq,
  input  logic [1:0] ringLines,
  input  logic       detN,
  input  logic       det1N,
  input  logic       det2N,
  output logic       lineD0,
  output logic       lineD1,
  output logic       lineD2,
  output logic       selP1,
  output logic       selP2
);

  dpCmd_t    cmd;
  dpFlags_t  flags;
  linePins_t pins;

  ring_sup_dp #(
    .HALF_CYC   (HALF_CYC),
    .BURST_CYC  (BURST_CYC),
    .PAUSE_CYC  (PAUSE_CYC),
    .PROBE_CYC  (PROBE_CYC),
    .ONHOOK_CYC (ONHOOK_CYC),
    .MAX_BURSTS (MAX_BURSTS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .detRaw ({det2N, det1N, detN}),
    .cmd    (cmd),
    .flags  (flags)
  );

  ring_sup_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .ringReq   (ringReq),
    .ringLines (ringLines),
    .flags     (flags),
    .cmd       (cmd),
    .pins      (pins)
  );

  assign lineD0 = pins.d0;
  assign lineD1 = pins.d1;
  assign lineD2 = pins.d2;
  assign selP1  = pins.p1;
  assign selP2  = pins.p2;

endmodule

// File: tb/ring_sup_ctrl_bench.sv
`timescale 1ns/1ps
module ring_sup_ctrl_bench;

  localparam int HALF   = 8;
  localparam int BURST  = 64;
  localparam int PAUSE  = 48;
  localparam int PROBE  = 6;
  localparam int ONHOOK = 20;
  localparam int NBURST = 3;

  localparam logic [4:0] PIN_IDLE = 5'b00011;
  localparam logic [4:0] PIN_ACT1 = 5'b01010;
  localparam logic [4:0] PIN_ACT2 = 5'b01001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringReq = 1'b0;
  logic [1:0] ringLines = 2'b00;
  logic hook1 = 1'b0, hook2 = 1'b0;
  logic detN, det1N, det2N;
  logic lineD0, lineD1, lineD2, selP1, selP2;
  int testCnt = 0, failCnt = 0;

  always #2.5 clk = ~clk;

  ring_sup_ctrl #(
    .HALF_CYC(HALF), .BURST_CYC(BURST), .PAUSE_CYC(PAUSE),
    .PROBE_CYC(PROBE), .ONHOOK_CYC(ONHOOK), .MAX_BURSTS(NBURST)
  ) u_ring_sup_ctrl (
    .clk(clk), .rstN(rstN), .ringReq(ringReq), .ringLines(ringLines),
    .detN(detN), .det1N(det1N), .det2N(det2N),
    .lineD0(lineD0), .lineD1(lineD1), .lineD2(lineD2),
    .selP1(selP1), .selP2(selP2)
  );

  // line model: detectors follow hook state as gated by the driven mode
  wire hiZ  = !lineD0 && !lineD1;
  wire off1 = selP1 && hook1;
  wire off2 = selP2 && hook2;
  assign det1N = !(hiZ && off1);
  assign det2N = !(hiZ && off2);
  assign detN  = hiZ ? (det1N && det2N) : !(off1 || off2);

  wire [4:0] pinsNow = {lineD0, lineD1, lineD2, selP1, selP2};

  // vectors: {kind, ringLines[1:0], hooks{h2,h1}, expP{P1,P2}}
  // kind 0: off-hook from idle; kind 1: ring then answer during burst
  localparam int NV = 7;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_00_01_10,   // R2 port 1
    7'b0_00_10_01,   // R2 port 2
    7'b0_00_11_10,   // R2 both, port 1 wins
    7'b1_01_01_10,   // R5 ring port 1, answer 1
    7'b1_10_10_01,   // R5 ring port 2, answer 2
    7'b1_11_10_01,   // R6 ring both, answer 2
    7'b1_11_01_10    // R6 ring both, answer 1
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: pins actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRing(input logic [1:0] lines);
    @(negedge clk);
    ringReq = 1'b1;
    ringLines = lines;
    @(negedge clk);
    ringReq = 1'b0;
    ringLines = 2'b00;
  endtask

  task automatic waitD0(input logic v, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (lineD0 == v) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    bit ok;
    cyc(4);
    chk("R1 in reset", pinsNow, PIN_IDLE);
    rstN = 1'b1;
    cyc(3);
    chk("R1 after reset", pinsNow, PIN_IDLE);

    // R9: latency through the synchronisers
    @(negedge clk);
    hook1 = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R9 still idle after two edges", pinsNow, PIN_IDLE);
    @(posedge clk);
    #1 chk("R9 active after third edge", pinsNow, PIN_ACT1);
    @(negedge clk);
    hook1 = 1'b0;
    cyc(ONHOOK + 10);
    chk("R8 back to idle", pinsNow, PIN_IDLE);

    // table walk
    for (int v = 0; v < NV; v++) begin
      if (!VEC[v][6]) begin
        {hook2, hook1} = VEC[v][3:2];
        cyc(10);
        chk("R2 idle off-hook", pinsNow, {3'b010, VEC[v][1:0]});
      end else begin
        pulseRing(VEC[v][5:4]);
        waitD0(1'b1, 5, ok);
        chk("R3 burst mode and ports", pinsNow & 5'b11011, {3'b100, VEC[v][4], VEC[v][5]});
        cyc(10);
        {hook2, hook1} = VEC[v][3:2];
        cyc(30);
        chk(VEC[v][5:4] == 2'b11 ? "R6 answering port found" : "R5 trip connects port",
            pinsNow, {3'b010, VEC[v][1:0]});
      end
      @(negedge clk);
      {hook2, hook1} = 2'b00;
      cyc(ONHOOK + 10);
      chk("R8 idle after call", pinsNow, PIN_IDLE);
    end

    // R3 / R4: cadence, polarity spacing and burst count without answer
    begin
      int idx, firstEdge, gap, lastEdge, burstLen, pauseLen, nBursts, run0;
      logic prevD2, prevD0;
      idx = 0; firstEdge = -1; gap = -1; lastEdge = -1;
      burstLen = 0; pauseLen = 0; nBursts = 0; run0 = 0;
      pulseRing(2'b10);
      waitD0(1'b1, 5, ok);
      prevD2 = lineD2; prevD0 = 1'b0;
      for (int i = 0; i < NBURST * (BURST + PAUSE) + 20; i++) begin
        if (lineD0 && !prevD0) nBursts++;
        if (lineD0 && nBursts == 1) begin
          burstLen++;
          if (lineD2 != prevD2) begin
            if (firstEdge < 0) firstEdge = idx;
            else if (gap < 0) gap = idx - lastEdge;
            lastEdge = idx;
          end
        end
        if (!lineD0 && nBursts == 1) pauseLen++;
        if (!lineD0 && nBursts == 1 && pinsNow != PIN_IDLE) run0++;
        prevD2 = lineD2; prevD0 = lineD0;
        idx++;
        @(negedge clk);
      end
      chkInt("R3 first D2 inversion", firstEdge, HALF);
      chkInt("R3 D2 half period", gap, HALF);
      chkInt("R4 burst length", burstLen, BURST);
      chkInt("R4 pause length", pauseLen, PAUSE);
      chkInt("R4 pause uses idle pins", run0, 0);
      chkInt("R4 burst count", nBursts, NBURST);
      chk("R4 idle after cadence", pinsNow, PIN_IDLE);
    end

    // R7: answer during a pause
    pulseRing(2'b01);
    waitD0(1'b1, 5, ok);
    waitD0(1'b0, BURST + 5, ok);
    cyc(5);
    hook1 = 1'b1;
    cyc(10);
    chk("R7 pause answer port 1", pinsNow, PIN_ACT1);
    hook1 = 1'b0;
    cyc(ONHOOK + 10);

    // R6: short trip, no port found on probing
    pulseRing(2'b11);
    waitD0(1'b1, 5, ok);
    cyc(5);
    hook2 = 1'b1;
    cyc(4);
    hook2 = 1'b0;
    chk("R6 first probe P1 low", pinsNow, 5'b01001);
    cyc(PROBE);
    chk("R6 second probe P2 low", pinsNow, 5'b01010);
    cyc(PROBE + 5);
    chk("R6 no answer returns idle", pinsNow, PIN_IDLE);

    // R10: request ignored outside idle and with empty port set
    @(negedge clk);
    hook2 = 1'b1;
    cyc(10);
    pulseRing(2'b11);
    cyc(10);
    chk("R10 request ignored in active", pinsNow, PIN_ACT2);
    hook2 = 1'b0;
    cyc(ONHOOK + 10);
    pulseRing(2'b00);
    cyc(10);
    chk("R10 empty request ignored", pinsNow, PIN_IDLE);

    // R8: short on-hook ignored, exact persistence boundary
    hook1 = 1'b1;
    cyc(10);
    hook1 = 1'b0;
    cyc(ONHOOK - 4);
    hook1 = 1'b1;
    cyc(30);
    chk("R8 short on-hook ignored", pinsNow, PIN_ACT1);
    @(negedge clk);
    hook1 = 1'b0;
    repeat (ONHOOK + 1) @(posedge clk);
    #1 chk("R8 still active before limit", pinsNow, PIN_ACT1);
    @(posedge clk);
    #1 chk("R8 idle at limit", pinsNow, PIN_IDLE);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule